// File: doc/BRIEF.md
# Bayer Test Pattern Generator

This block sits at the head of a pixel pipeline. It can replace the sensor's pixel samples with a synthetic image, so that the downstream datapath can be exercised with known values. Alongside each sample it receives the frame, line and valid markers, the sample's column and row, and a flag that says whether the sample lies in the active image area or in a dark border. It also receives a pattern mode code and three 12-bit per-colour levels. It produces a 12-bit pixel stream that keeps the same timing, one clock cycle later.

The colour of each site follows a fixed Bayer layout taken from the row and column parity. In any pattern mode, a dark-border pixel takes the level programmed for its own colour site. An active pixel takes the value of the chosen pattern: a flat colour field, eight full-scale vertical bars, the same bars fading towards mid-gray down the frame, or a single one-bit moving across the row. Mode 0 leaves the stream untouched, and so does any mode code the block does not recognise.

Top module: `bayer_pattern_src`

## Requirements
- R1: With mode code 0, the output sample equals the input sample for every pixel, active or dark.
- R2: With mode code 1, each active pixel is replaced by the level for its Bayer site. An even row with an even column, or an odd row with an odd column, is a green site and takes the green level. An even row with an odd column takes the red level. An odd row with an even column takes the blue level.
- R3: With mode code 2, the active width ACT_W is cut into eight bars, each ACT_W/8 columns wide. Bar index = column / (ACT_W/8), held at 7 for larger columns. The bars run in the order white, yellow, cyan, green, magenta, red, blue, black. A site takes 0xFFF when its colour is part of the bar's colour, and 0 otherwise.
- R4: With mode code 3, the bar level from R3 is blended linearly towards mid-gray. With r = min(row, ACT_H-1), a full-scale site gives 0xFFF - (0x7FF*r)/(ACT_H-1) and a zero site gives (0x800*r)/(ACT_H-1), both using integer division. At the last active row both reach 0x800.
- R5: With mode code 256, an active pixel takes 1 << (column mod 12). Column 0 therefore gives 1, and the single set bit wraps from bit 11 back to bit 0.
- R6: In modes 1, 2, 3 and 256, a pixel whose active flag is low takes its Bayer-site level as defined in R2, whatever the pattern.
- R7: Any mode code other than 0, 1, 2, 3 and 256 behaves exactly like mode 0.
- R8: The output sample and the frame, line and valid markers appear exactly one clock cycle after their inputs. While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_frame | input | 1 | Frame-start marker of the incoming stream |
| in_line | input | 1 | Line-start marker of the incoming stream |
| in_valid | input | 1 | Incoming sample is valid |
| in_pix | input | DW (12) | Incoming sensor sample |
| in_col | input | COL_W (12) | Column of the sample within the active area |
| in_row | input | ROW_W (12) | Row of the sample within the active area |
| in_active | input | 1 | High for active-area pixels, low for dark pixels |
| mode | input | MODE_W (9) | Pattern selection code |
| lvl_red | input | DW (12) | Red-site level |
| lvl_grn | input | DW (12) | Green-site level |
| lvl_blu | input | DW (12) | Blue-site level |
| out_frame | output | 1 | Delayed frame-start marker |
| out_line | output | 1 | Delayed line-start marker |
| out_valid | output | 1 | Delayed valid |
| out_pix | output | DW (12) | Output sample |

## Verification
Random stimulus draws every legal mode code together with arbitrary unused codes. It also draws random positions, both inside and past the active window, random active flags and random per-colour levels. These draws separate the site colour mapping, the dark-pixel override and the pass-through for unrecognised codes. Directed cases pin down the boundaries: the walking bit at columns 0, 11 and 12; the first and last column of each bar; the first row and the last active row in fade mode, where both levels must meet at mid-gray; and dark pixels in mode 0, which must stay untouched. The markers are toggled at random to show that they keep the one-cycle alignment with the data.

// File: rtl/bayer_pattern_src.sv
module bayer_pattern_src #(
  parameter int DW     = 12,
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12,
  parameter int MODE_W = 9,
  parameter int ACT_W  = 64,
  parameter int ACT_H  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_frame,
  input  logic              in_line,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_pix,
  input  logic [COL_W-1:0]  in_col,
  input  logic [ROW_W-1:0]  in_row,
  input  logic              in_active,
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     lvl_red,
  input  logic [DW-1:0]     lvl_grn,
  input  logic [DW-1:0]     lvl_blu,
  output logic              out_frame,
  output logic              out_line,
  output logic              out_valid,
  output logic [DW-1:0]     out_pix
);

  localparam int          BAR_W  = ACT_W / 8;
  localparam logic [31:0] FULL32 = (32'd1 << DW) - 32'd1;
  localparam logic [31:0] GRAY32 = 32'd1 << (DW - 1);
  localparam logic [31:0] LAST_R = 32'(ACT_H - 1);
  localparam logic [31:0] WALK_N = 32'(DW);

  localparam logic [MODE_W-1:0] M_PASS  = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_SOLID = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_BARS  = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_FADE  = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_WALK  = MODE_W'(256);

  logic [31:0] col32, row32, bar_raw, row_cl, walk_idx;
  logic [31:0] fade_hi, fade_lo;
  logic [2:0]  bar_idx, rgb;
  logic        is_red, is_blu, is_grn, comp_on;
  logic [DW-1:0] site_lvl, bar_lvl, fade_lvl, walk_lvl, nxt_pix;

  assign col32 = 32'(in_col);
  assign row32 = 32'(in_row);

  assign is_red = ~in_row[0] &  in_col[0];
  assign is_blu =  in_row[0] & ~in_col[0];
  assign is_grn = ~(is_red | is_blu);

  assign site_lvl = is_red ? lvl_red : (is_blu ? lvl_blu : lvl_grn);

  assign bar_raw = col32 / 32'(BAR_W);
  assign bar_idx = (bar_raw > 32'd7) ? 3'd7 : bar_raw[2:0];

  always_comb begin
    case (bar_idx)
      3'd0:    rgb = 3'b111;
      3'd1:    rgb = 3'b110;
      3'd2:    rgb = 3'b011;
      3'd3:    rgb = 3'b010;
      3'd4:    rgb = 3'b101;
      3'd5:    rgb = 3'b100;
      3'd6:    rgb = 3'b001;
      default: rgb = 3'b000;
    endcase
  end

  assign comp_on = is_red ? rgb[2] : (is_grn ? rgb[1] : rgb[0]);
  assign bar_lvl = comp_on ? DW'(FULL32) : '0;

  assign row_cl  = (row32 > LAST_R) ? LAST_R : row32;
  assign fade_hi = FULL32 - ((FULL32 - GRAY32) * row_cl) / LAST_R;
  assign fade_lo = (GRAY32 * row_cl) / LAST_R;
  assign fade_lvl = comp_on ? DW'(fade_hi) : DW'(fade_lo);

  assign walk_idx = col32 % WALK_N;
  assign walk_lvl = DW'(32'd1 << walk_idx);

  always_comb begin
    nxt_pix = in_pix;
    case (mode)
      M_SOLID: nxt_pix = site_lvl;
      M_BARS:  nxt_pix = in_active ? bar_lvl  : site_lvl;
      M_FADE:  nxt_pix = in_active ? fade_lvl : site_lvl;
      M_WALK:  nxt_pix = in_active ? walk_lvl : site_lvl;
      M_PASS:  nxt_pix = in_pix;
      default: nxt_pix = in_pix;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_frame <= 1'b0;
      out_line  <= 1'b0;
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_frame <= in_frame;
      out_line  <= in_line;
      out_valid <= in_valid;
      out_pix   <= nxt_pix;
    end
  end

endmodule

// File: rtl/bayer_pattern_src_chk.sv
module bayer_pattern_src_chk #(
  parameter int DW     = 12,
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12,
  parameter int MODE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_frame,
  input logic              in_line,
  input logic              in_valid,
  input logic [DW-1:0]     in_pix,
  input logic [COL_W-1:0]  in_col,
  input logic [ROW_W-1:0]  in_row,
  input logic              in_active,
  input logic [MODE_W-1:0] mode,
  input logic [DW-1:0]     lvl_grn,
  input logic              out_frame,
  input logic              out_line,
  input logic              out_valid,
  input logic [DW-1:0]     out_pix
);

  AST_MARKER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)) && (out_frame == $past(in_frame))
                     && (out_line == $past(in_line))); // R8

  AST_MODE0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == '0) |-> out_pix == $past(in_pix)); // R1

  AST_SOLID_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == MODE_W'(1) && ($past(in_row[0]) == $past(in_col[0])))
      |-> out_pix == $past(lvl_grn)); // R2

  AST_BAR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == MODE_W'(2) && $past(in_active))
      |-> (out_pix == '0 || out_pix == {DW{1'b1}})); // R3

  AST_WALK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == MODE_W'(256) && $past(in_active))
      |-> $countones(out_pix) == 1); // R5

  AST_DARK_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_active) && ($past(in_row[0]) == $past(in_col[0]))
     && ($past(mode) == MODE_W'(2) || $past(mode) == MODE_W'(3) || $past(mode) == MODE_W'(256)))
      |-> out_pix == $past(lvl_grn)); // R6

  always_comb begin
    if (!rst_n) begin
      AST_RESET_ZERO: assert (out_pix == '0 && !out_valid && !out_frame && !out_line); // R8
    end
  end

endmodule

bind bayer_pattern_src bayer_pattern_src_chk #(
  .DW(DW), .COL_W(COL_W), .ROW_W(ROW_W), .MODE_W(MODE_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .in_line(in_line), .in_valid(in_valid),
  .in_pix(in_pix), .in_col(in_col), .in_row(in_row), .in_active(in_active), .mode(mode),
  .lvl_grn(lvl_grn), .out_frame(out_frame), .out_line(out_line), .out_valid(out_valid),
  .out_pix(out_pix)
);

// File: tb/test_bayer_pattern_src.sv
module test_bayer_pattern_src;
  localparam int CLK_PERIOD = 10;
  localparam int ACT_W = 64;
  localparam int ACT_H = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_frame = 0, in_line = 0, in_valid = 0, in_active = 0;
  logic [11:0] in_pix = 0, in_col = 0, in_row = 0;
  logic [8:0]  mode = 0;
  logic [11:0] lvl_red = 0, lvl_grn = 0, lvl_blu = 0;
  logic out_frame, out_line, out_valid;
  logic [11:0] out_pix;

  int checks = 0;
  int fails = 0;
  bit have_exp = 0;
  logic [11:0] exp_pix;
  logic [2:0]  exp_mark;
  string exp_req;

  bayer_pattern_src #(.ACT_W(ACT_W), .ACT_H(ACT_H)) i_bayer_pattern_src (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .in_line(in_line), .in_valid(in_valid),
    .in_pix(in_pix), .in_col(in_col), .in_row(in_row), .in_active(in_active), .mode(mode),
    .lvl_red(lvl_red), .lvl_grn(lvl_grn), .lvl_blu(lvl_blu),
    .out_frame(out_frame), .out_line(out_line), .out_valid(out_valid), .out_pix(out_pix));

  always #(CLK_PERIOD/2) clk = ~clk;

  // 0 green, 1 red, 2 blue
  function automatic int site_of(int row, int col);
    if ((row % 2) == (col % 2)) return 0;
    if ((row % 2) == 0) return 1;
    return 2;
  endfunction

  function automatic logic [11:0] site_level(int row, int col, logic [11:0] r, logic [11:0] g, logic [11:0] b);
    case (site_of(row, col))
      1: return r;
      2: return b;
      default: return g;
    endcase
  endfunction

  function automatic bit bar_on(int row, int col);
    int bar;
    bit [2:0] c;
    bar = col / (ACT_W / 8);
    if (bar > 7) bar = 7;
    case (bar)
      0: c = 3'b111; 1: c = 3'b110; 2: c = 3'b011; 3: c = 3'b010;
      4: c = 3'b101; 5: c = 3'b100; 6: c = 3'b001; default: c = 3'b000;
    endcase
    case (site_of(row, col))
      1: return c[2];
      2: return c[0];
      default: return c[1];
    endcase
  endfunction

  function automatic logic [11:0] model(int md, bit act, int row, int col, logic [11:0] d,
                                       logic [11:0] r, logic [11:0] g, logic [11:0] b);
    int rc;
    if (md != 1 && md != 2 && md != 3 && md != 256) return d;
    if (md == 1 || !act) return site_level(row, col, r, g, b);
    if (md == 2) return bar_on(row, col) ? 12'hFFF : 12'h000;
    if (md == 3) begin
      rc = (row > ACT_H - 1) ? ACT_H - 1 : row;
      if (bar_on(row, col)) return 12'(4095 - (2047 * rc) / (ACT_H - 1));
      return 12'((2048 * rc) / (ACT_H - 1));
    end
    return 12'(1 << (col % 12));
  endfunction

  function automatic string req_of(int md, bit act);
    if (md != 1 && md != 2 && md != 3 && md != 256) return (md == 0) ? "R1" : "R7";
    if (md == 1) return "R2";
    if (!act) return "R6";
    if (md == 2) return "R3";
    if (md == 3) return "R4";
    return "R5";
  endfunction

  task automatic compare();
    if (!have_exp) return;
    checks++;
    if (out_pix !== exp_pix) begin
      fails++;
      $display("FAIL %s: pixel got %h expected %h", exp_req, out_pix, exp_pix);
    end
    checks++;
    if ({out_frame, out_line, out_valid} !== exp_mark) begin
      fails++;
      $display("FAIL R8: markers got %b expected %b", {out_frame, out_line, out_valid}, exp_mark);
    end
  endtask

  task automatic apply(int md, bit act, int row, int col, logic [11:0] d, logic [2:0] mk);
    @(negedge clk);
    compare();
    mode = 9'(md); in_active = act; in_row = 12'(row); in_col = 12'(col); in_pix = d;
    {in_frame, in_line, in_valid} = mk;
    exp_pix  = model(md, act, row, col, d, lvl_red, lvl_grn, lvl_blu);
    exp_mark = mk;
    exp_req  = req_of(md, act);
    have_exp = 1;
  endtask

  function automatic int pick_mode();
    case ($urandom_range(0, 5))
      0: return 0; 1: return 1; 2: return 2; 3: return 3; 4: return 256;
      default: return int'($urandom_range(4, 511));
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    lvl_red = 12'h3A5; lvl_grn = 12'h5C6; lvl_blu = 12'h0F1;
    in_pix = 12'hABC; in_valid = 1; in_frame = 1; in_line = 1; mode = 9'd1;
    repeat (3) @(negedge clk);
    checks++; // R8 reset state
    if (out_pix !== 0 || {out_frame, out_line, out_valid} !== 3'b000) begin
      fails++;
      $display("FAIL R8: reset outputs got %h/%b expected 0/000", out_pix, {out_frame, out_line, out_valid});
    end
    rst_n = 1'b1;

    // R5 walking-one boundaries
    apply(256, 1, 0, 0, 12'h123, 3'b111);
    apply(256, 1, 0, 11, 12'h123, 3'b001);
    apply(256, 1, 1, 12, 12'h123, 3'b001);
    apply(256, 1, 5, 25, 12'h123, 3'b000);
    // R3 bar edges
    for (int c = 0; c < 8; c++) begin
      apply(2, 1, 0, c * (ACT_W / 8), 12'h0, 3'b001);
      apply(2, 1, 1, c * (ACT_W / 8) + (ACT_W / 8) - 1, 12'h0, 3'b001);
    end
    apply(2, 1, 0, ACT_W + 5, 12'h0, 3'b001);
    // R4 first and last rows, beyond the last row
    apply(3, 1, 0, 0, 12'h0, 3'b001);
    apply(3, 1, ACT_H - 1, 0, 12'h0, 3'b001);
    apply(3, 1, ACT_H - 1, ACT_W - 1, 12'h0, 3'b001);
    apply(3, 1, ACT_H + 3, 9, 12'h0, 3'b001);
    // R2 all sites
    apply(1, 1, 0, 0, 12'h777, 3'b001);
    apply(1, 1, 0, 1, 12'h777, 3'b001);
    apply(1, 1, 1, 0, 12'h777, 3'b001);
    apply(1, 1, 1, 1, 12'h777, 3'b001);
    // R6 dark pixels, R1 dark passthrough, R7 unused codes
    apply(256, 0, 2, 3, 12'h777, 3'b001);
    apply(3, 0, 3, 2, 12'h777, 3'b001);
    apply(0, 0, 3, 2, 12'h9D2, 3'b001);
    apply(4, 1, 0, 0, 12'h444, 3'b001);
    apply(257, 1, 0, 0, 12'h555, 3'b001);
    apply(511, 0, 1, 0, 12'h666, 3'b010);

    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        @(negedge clk);
        compare();
        have_exp = 0;
        lvl_red = 12'($urandom); lvl_grn = 12'($urandom); lvl_blu = 12'($urandom);
      end
      apply(pick_mode(), ($urandom_range(0, 4) != 0),
            int'($urandom_range(0, ACT_H + 3)), int'($urandom_range(0, ACT_W + 7)),
            12'($urandom), 3'($urandom));
    end
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule